// File: doc/BRIEF.md
# Barrel-Scheduled Ten-Context Sequencer

This block shares a single execution datapath among ten independent program contexts. Each context owns its own state (program counter, 12-bit accumulator, step phase and a pending-read flag) and its own small private program store. A ring counter hands the execution slot to the next context on every clock, in fixed round-robin order, so each context is active exactly one cycle out of every ten. During its slot a context performs one step of its current instruction and its updated state is written back; contexts outside the slot hold still.

The instruction set has four operations encoded in a 12-bit word: load the accumulator from central memory, add a central memory word into it, store it to central memory, and jump. Central memory reads have a fixed latency of ten cycles, equal to the rotation period, so a read issued in a context's slot is answered exactly when that context next holds the slot and no stall logic is needed. Program stores are filled through a separate load port, typically while the block is held in reset.

Top module: `barrel_seq`

## Requirements
- R1: While reset is asserted, and until it is released, the slot index is 0, every busy flag is 0, and the program counter and accumulator shown for the slot context are 0.
- R2: Outside reset the slot index advances by one every cycle and wraps from 9 back to 0.
- R3: Only the context holding the slot changes state; from one cycle to the next at most one busy flag changes, and only that of the context that held the slot in the earlier cycle.
- R4: Opcode bits [11:10] = 00 (load): in the issue step a read request for address bits [9:0] is made and the context's busy flag sets; in its next slot the accumulator takes mem_rdata, the program counter increments and busy clears.
- R5: Opcode 01 (add): same two-step pattern as load, but the accumulator takes the sum of its old value and mem_rdata modulo 4096.
- R6: Opcode 10 (store): in a single slot a write request carries the accumulator to address bits [9:0], the program counter increments, and busy stays clear.
- R7: Opcode 11 (jump): in a single slot the program counter takes bits [9:0] zero-extended, no memory request is made, and the skipped instructions have no effect.
- R8: A memory request is made only by the context in the slot, only when that context is not busy, and so at most once per rotation per context.
- R9: A write on the load port with ld_en high places ld_data into the program store of context ld_ctx at word ld_addr only; each context runs its own program from word 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_en | input | 1 | Program store write strobe |
| ld_ctx | input | 4 | Context whose program store is written |
| ld_addr | input | 6 | Word index within that program store |
| ld_data | input | 12 | Instruction word to write |
| mem_req | output | 1 | Central memory request this cycle |
| mem_we | output | 1 | Request is a write (1) or read (0) |
| mem_addr | output | 10 | Central memory word address |
| mem_wdata | output | 12 | Write data (accumulator of slot context) |
| mem_rdata | input | 12 | Read data, valid ten cycles after the read request |
| slot_idx | output | 4 | Context currently holding the slot |
| busy | output | 10 | Per-context flag: a read is outstanding |
| cur_pc | output | 12 | Program counter of the slot context |
| cur_acc | output | 12 | Accumulator of the slot context |

## Verification
All ten contexts run distinct programs at once, each touching its own central addresses, so a result landing in the wrong context or a read answered on the wrong rotation shows up as a wrong stored word. Operand values are derived arithmetically and two passes with different seeds are run, one forcing an add that wraps past 4095 to zero, which separates a correct modulo add from a carry or width slip. A jump over a store to a watched address distinguishes a correct jump from a fall-through, and a cycle-by-cycle monitor of slot order, busy transitions and request timing separates correct scheduling from a stuck or skipping barrel.

// File: rtl/barrel_seq_pkg.sv
package barrel_seq_pkg;

  localparam int OP_W = 2;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_ADD   = 2'd1,
    OP_STORE = 2'd2,
    OP_JUMP  = 2'd3
  } op_e;

  typedef enum logic {
    PH_ISSUE  = 1'b0,
    PH_RETIRE = 1'b1
  } phase_e;

endpackage

// File: rtl/barrel_ring.sv
module barrel_ring #(
  parameter int NUM_CTX = 10,
  parameter int CTX_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CTX_W-1:0] slot_o
);

  logic [CTX_W-1:0] slot_q;
  logic [CTX_W-1:0] slot_d;

  always_comb begin
    if (slot_q == CTX_W'(NUM_CTX - 1)) begin
      slot_d = '0;
    end else begin
      slot_d = slot_q + CTX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else begin
      slot_q <= slot_d;
    end
  end

  assign slot_o = slot_q;

endmodule

// File: rtl/ctx_store.sv
module ctx_store
  import barrel_seq_pkg::*;
#(
  parameter int NUM_CTX = 10,
  parameter int CTX_W   = 4,
  parameter int DATA_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTX_W-1:0]  slot_i,
  input  logic [DATA_W-1:0] pc_d_i,
  input  logic [DATA_W-1:0] acc_d_i,
  input  phase_e            ph_d_i,
  input  logic              pend_d_i,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] acc_o,
  output phase_e            ph_o,
  output logic              pend_o,
  output logic [NUM_CTX-1:0] busy_o
);

  logic [DATA_W-1:0] pc_q  [NUM_CTX];
  logic [DATA_W-1:0] acc_q [NUM_CTX];
  phase_e            ph_q  [NUM_CTX];
  logic [NUM_CTX-1:0] pend_q;
  logic [NUM_CTX-1:0] ce;

  // one clock enable per context, high only while it holds the slot
  always_comb begin
    for (int i = 0; i < NUM_CTX; i++) begin
      ce[i] = (slot_i == CTX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CTX; i++) begin
        pc_q[i]  <= '0;
        acc_q[i] <= '0;
        ph_q[i]  <= PH_ISSUE;
      end
      pend_q <= '0;
    end else begin
      for (int i = 0; i < NUM_CTX; i++) begin
        if (ce[i]) begin
          pc_q[i]   <= pc_d_i;
          acc_q[i]  <= acc_d_i;
          ph_q[i]   <= ph_d_i;
          pend_q[i] <= pend_d_i;
        end
      end
    end
  end

  always_comb begin
    pc_o   = '0;
    acc_o  = '0;
    ph_o   = PH_ISSUE;
    pend_o = 1'b0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (ce[i]) begin
        pc_o   = pc_q[i];
        acc_o  = acc_q[i];
        ph_o   = ph_q[i];
        pend_o = pend_q[i];
      end
    end
  end

  assign busy_o = pend_q;

endmodule

// File: rtl/local_store.sv
module local_store #(
  parameter int NUM_CTX = 10,
  parameter int CTX_W   = 4,
  parameter int DATA_W  = 12,
  parameter int LADDR_W = 6
) (
  input  logic               clk,
  input  logic               wr_en_i,
  input  logic [CTX_W-1:0]   wr_ctx_i,
  input  logic [LADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [CTX_W-1:0]   rd_ctx_i,
  input  logic [LADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o
);

  localparam int DEPTH = 1 << LADDR_W;

  logic [DATA_W-1:0] words_q [NUM_CTX][DEPTH];
  logic [DATA_W-1:0] per_ctx [NUM_CTX];

  // program storage carries no reset so it can be filled while reset is held
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CTX; i++) begin
      if (wr_en_i && (wr_ctx_i == CTX_W'(i))) begin
        words_q[i][wr_addr_i] <= wr_data_i;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CTX; g++) begin : g_rd
      assign per_ctx[g] = words_q[g][rd_addr_i];
    end
  endgenerate

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (rd_ctx_i == CTX_W'(i)) begin
        rd_data_o = per_ctx[i];
      end
    end
  end

endmodule

// File: rtl/step_unit.sv
module step_unit
  import barrel_seq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic [DATA_W-1:0]      instr_i,
  input  logic [DATA_W-1:0]      pc_i,
  input  logic [DATA_W-1:0]      acc_i,
  input  phase_e                 ph_i,
  input  logic                   pend_i,
  input  logic [DATA_W-1:0]      rdata_i,
  output logic [DATA_W-1:0]      pc_o,
  output logic [DATA_W-1:0]      acc_o,
  output phase_e                 ph_o,
  output logic                   pend_o,
  output logic                   req_o,
  output logic                   we_o,
  output logic [DATA_W-OP_W-1:0] addr_o,
  output logic [DATA_W-1:0]      wdata_o
);

  localparam int FIELD_W = DATA_W - OP_W;

  op_e               op;
  logic [FIELD_W-1:0] field;

  assign op    = op_e'(instr_i[DATA_W-1 -: OP_W]);
  assign field = instr_i[FIELD_W-1:0];

  always_comb begin
    pc_o    = pc_i;
    acc_o   = acc_i;
    ph_o    = ph_i;
    pend_o  = pend_i;
    req_o   = 1'b0;
    we_o    = 1'b0;
    addr_o  = field;
    wdata_o = acc_i;
    if (ph_i == PH_ISSUE) begin
      unique case (op)
        OP_LOAD, OP_ADD: begin
          req_o  = 1'b1;
          ph_o   = PH_RETIRE;
          pend_o = 1'b1;
        end
        OP_STORE: begin
          req_o = 1'b1;
          we_o  = 1'b1;
          pc_o  = pc_i + DATA_W'(1);
        end
        OP_JUMP: begin
          pc_o = {{OP_W{1'b0}}, field};
        end
        default: begin
          pc_o = pc_i;
        end
      endcase
    end else begin
      // read data arrives exactly one rotation after the request
      if (op == OP_ADD) begin
        acc_o = acc_i + rdata_i;
      end else begin
        acc_o = rdata_i;
      end
      pc_o   = pc_i + DATA_W'(1);
      ph_o   = PH_ISSUE;
      pend_o = 1'b0;
    end
  end

endmodule

// File: rtl/barrel_seq.sv
module barrel_seq
  import barrel_seq_pkg::*;
#(
  parameter int NUM_CTX = 10,
  parameter int DATA_W  = 12,
  parameter int LADDR_W = 6,
  localparam int CTX_W   = $clog2(NUM_CTX),
  localparam int CADDR_W = DATA_W - OP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_en,
  input  logic [CTX_W-1:0]   ld_ctx,
  input  logic [LADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0]  ld_data,
  output logic               mem_req,
  output logic               mem_we,
  output logic [CADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [CTX_W-1:0]   slot_idx,
  output logic [NUM_CTX-1:0] busy,
  output logic [DATA_W-1:0]  cur_pc,
  output logic [DATA_W-1:0]  cur_acc
);

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic [CTX_W-1:0]  slot;
  logic [DATA_W-1:0] pc_cur, acc_cur, pc_nxt, acc_nxt, instr;
  phase_e            ph_cur, ph_nxt;
  logic              pend_cur, pend_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  barrel_ring #(
    .NUM_CTX (NUM_CTX),
    .CTX_W   (CTX_W)
  ) u_ring (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .slot_o (slot)
  );

  ctx_store #(
    .NUM_CTX (NUM_CTX),
    .CTX_W   (CTX_W),
    .DATA_W  (DATA_W)
  ) u_ctx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .slot_i   (slot),
    .pc_d_i   (pc_nxt),
    .acc_d_i  (acc_nxt),
    .ph_d_i   (ph_nxt),
    .pend_d_i (pend_nxt),
    .pc_o     (pc_cur),
    .acc_o    (acc_cur),
    .ph_o     (ph_cur),
    .pend_o   (pend_cur),
    .busy_o   (busy)
  );

  local_store #(
    .NUM_CTX (NUM_CTX),
    .CTX_W   (CTX_W),
    .DATA_W  (DATA_W),
    .LADDR_W (LADDR_W)
  ) u_prog (
    .clk       (clk),
    .wr_en_i   (ld_en),
    .wr_ctx_i  (ld_ctx),
    .wr_addr_i (ld_addr),
    .wr_data_i (ld_data),
    .rd_ctx_i  (slot),
    .rd_addr_i (pc_cur[LADDR_W-1:0]),
    .rd_data_o (instr)
  );

  step_unit #(
    .DATA_W (DATA_W)
  ) u_step (
    .instr_i (instr),
    .pc_i    (pc_cur),
    .acc_i   (acc_cur),
    .ph_i    (ph_cur),
    .pend_i  (pend_cur),
    .rdata_i (mem_rdata),
    .pc_o    (pc_nxt),
    .acc_o   (acc_nxt),
    .ph_o    (ph_nxt),
    .pend_o  (pend_nxt),
    .req_o   (mem_req),
    .we_o    (mem_we),
    .addr_o  (mem_addr),
    .wdata_o (mem_wdata)
  );

  assign slot_idx = slot;
  assign cur_pc   = pc_cur;
  assign cur_acc  = acc_cur;

endmodule

// File: rtl/barrel_seq_chk.sv
module barrel_seq_chk #(
  parameter int NUM_CTX = 10,
  parameter int CTX_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CTX_W-1:0]   slot_idx,
  input logic [NUM_CTX-1:0] busy,
  input logic               mem_req,
  input logic               mem_we
);

  assert_slot_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 ##0 mem_req || !mem_req |=> slot_idx ==
      (($past(slot_idx) == CTX_W'(NUM_CTX - 1)) ? '0 : $past(slot_idx) + CTX_W'(1)));

  assert_single_ctx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy ^ $past(busy)) <= 1);

  assert_read_marks_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> $countones(busy) == $past($countones(busy)) + 1);

  assert_store_no_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |=> busy == $past(busy));

  assert_req_idle_ctx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !busy[slot_idx]);

endmodule

bind barrel_seq barrel_seq_chk #(
  .NUM_CTX (NUM_CTX),
  .CTX_W   (CTX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .slot_idx (slot_idx),
  .busy     (busy),
  .mem_req  (mem_req),
  .mem_we   (mem_we)
);

// File: tb/barrel_seq_tb.sv
module barrel_seq_tb;

  localparam int NC = 10;
  localparam int LAT = 10;

  logic        clk;
  logic        rst_n;
  logic        ld_en;
  logic [3:0]  ld_ctx;
  logic [5:0]  ld_addr;
  logic [11:0] ld_data;
  logic        mem_req, mem_we;
  logic [9:0]  mem_addr;
  logic [11:0] mem_wdata, mem_rdata;
  logic [3:0]  slot_idx;
  logic [9:0]  busy;
  logic [11:0] cur_pc, cur_acc;

  int total, bad;
  int cyc;
  bit done;
  bit mon_on, mon_first;
  logic [3:0] prev_slot;
  logic [9:0] prev_busy;

  logic [11:0] cmem [1024];
  logic [11:0] init_m [1024];
  logic [11:0] pipe [LAT];

  barrel_seq u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .ld_ctx    (ld_ctx),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .slot_idx  (slot_idx),
    .busy      (busy),
    .cur_pc    (cur_pc),
    .cur_acc   (cur_acc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // central memory: ten-cycle read pipe, write at the request edge
  always @(posedge clk) begin
    pipe[0] <= (mem_req && !mem_we) ? cmem[mem_addr] : 12'h000;
    for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    if (mem_req && mem_we) cmem[mem_addr] <= mem_wdata;
  end
  assign mem_rdata = pipe[LAT-1];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // cycle monitor: slot order, busy transitions, request legality
  always @(negedge clk) begin
    if (mon_on) begin
      if (!mon_first) begin
        chk(slot_idx == ((prev_slot == 4'd9) ? 4'd0 : prev_slot + 4'd1), "R2 slot order",
            slot_idx, (prev_slot == 4'd9) ? 0 : prev_slot + 1);
        chk((busy ^ prev_busy) == 10'd0 || (busy ^ prev_busy) == (10'd1 << prev_slot),
            "R3 busy change", busy ^ prev_busy, 10'd1 << prev_slot);
      end
      if (mem_req) chk(!busy[slot_idx], "R8 request while busy", busy[slot_idx], 0);
      mon_first = 1'b0;
      prev_slot = slot_idx;
      prev_busy = busy;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [11:0] enc(input logic [1:0] op, input int f);
    return {op, 10'(f)};
  endfunction

  task automatic load_word(input int c, input int a, input logic [11:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_ctx = 4'(c); ld_addr = 6'(a); ld_data = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_pass(input int p);
    logic [11:0] d, e;
    rst_n = 1'b0;
    mon_on = 1'b0;
    for (int a = 0; a < 1024; a++) cmem[a] = 12'((a * 613 + p * 1777 + 2900) & 12'hFFF);
    if (p == 0) begin
      cmem[16] = 12'hFFF;  // add wraps to zero for context 0
      cmem[32] = 12'h001;
    end
    for (int a = 0; a < 1024; a++) init_m[a] = cmem[a];
    // R9: each context gets its own program, written through the load port
    for (int c = 0; c < NC; c++) begin
      load_word(c, 0, enc(2'd0, 16 + c + p * 100));
      load_word(c, 1, enc(2'd1, 32 + c + p * 100));
      load_word(c, 2, enc(2'd2, 64 + c + p * 100));
      load_word(c, 3, enc(2'd3, 5));
      load_word(c, 4, enc(2'd2, 200 + c + p * 100));
      load_word(c, 5, enc(2'd1, 16 + c + p * 100));
      load_word(c, 6, enc(2'd2, 80 + c + p * 100));
      load_word(c, 7, enc(2'd3, 7));
    end
    @(negedge clk);
    chk(slot_idx == 4'd0, "R1 reset slot", slot_idx, 0);
    chk(busy == 10'd0, "R1 reset busy", busy, 0);
    chk(cur_pc == 12'd0 && cur_acc == 12'd0, "R1 reset pc/acc", {cur_pc, cur_acc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(slot_idx == 4'd0, "R1 slot held during release", slot_idx, 0);
    repeat (3) @(negedge clk);
    mon_first = 1'b1;
    mon_on = 1'b1;
    repeat (250) @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      int ba = 16 + c + p * 100;
      d = init_m[ba] + init_m[32 + c + p * 100];
      e = d + init_m[ba];
      chk(cmem[64 + c + p * 100] == d, "R4 R5 R6 load/add/store", cmem[64 + c + p * 100], d);
      chk(cmem[80 + c + p * 100] == e, "R5 R6 second sum", cmem[80 + c + p * 100], e);
      chk(cmem[200 + c + p * 100] == init_m[200 + c + p * 100], "R7 skipped store",
          cmem[200 + c + p * 100], init_m[200 + c + p * 100]);
    end
    if (p == 0) chk(cmem[64] == 12'h000, "R5 wrap to zero", cmem[64], 0);
    for (int k = 0; k < NC; k++) begin
      @(negedge clk);
      e = init_m[32 + slot_idx + p * 100] + init_m[16 + slot_idx + p * 100]
          + init_m[16 + slot_idx + p * 100];
      chk(cur_pc == 12'd7, "R7 jump target held", cur_pc, 7);
      chk(cur_acc == e, "R9 context accumulator", cur_acc, e);
      chk(!mem_req, "R7 jump makes no request", mem_req, 0);
    end
    mon_on = 1'b0;
  endtask

  initial begin
    total = 0; bad = 0; cyc = 0; done = 1'b0;
    mon_on = 1'b0; mon_first = 1'b1;
    prev_slot = '0; prev_busy = '0;
    ld_en = 1'b0; ld_ctx = '0; ld_addr = '0; ld_data = '0;
    rst_n = 1'b0;
    for (int i = 0; i < LAT; i++) pipe[i] = 12'h000;
    run_pass(0);
    run_pass(1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule